// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits behind a receive MAC and decides whether each incoming frame is kept. It watches the frame as a byte stream, captures the six destination address bytes, counts the frame length, and runs a CRC-32 over the address to pick one bin of a 64-bin group hash table. When the last byte arrives, it applies the acceptance rules. These rules cover exact station match, promiscuous unicast, broadcast enable, hashed multicast, minimum length and the error flags. The verdict appears as a one-cycle pulse in the next cycle.

The CRC checker is not part of the block. The receive path reports its result, together with an alignment flag, as two inputs that are valid alongside the last byte. The station address, the hash table and the five enables are static configuration inputs. They must stay stable from the first byte of a frame until its verdict. The block handles frames back to back with no idle cycle between them.

Top module: `rx_dest_filter`

## Requirements
- R1: A destination of all ones (broadcast) is accepted only when `cfg_acc_bcast` is 1, whatever the hash table and the multicast enable hold.
- R2: A non-broadcast destination whose first received byte has bit 0 set (group address) is accepted only when `cfg_acc_mcast` is 1 and its hash bin is set in `hash_table`. With `cfg_acc_mcast` at 0 it is rejected.
- R3: The hash bin is found as follows. Take a 32-bit register seeded with all ones. Feed it the six destination bytes in arrival order, each byte LSB first. For each bit, compute fb = reg[31] xor bit, shift reg left by one, and xor in 0x04C11DB7 when fb is 1. There is no final inversion. The bin index is reg[31:26], and bin n is `hash_table[n]`, so byte n/8 holds bit n%8.
- R4: A unicast destination (first byte bit 0 clear) is accepted when `cfg_promisc` is 1 or when it equals `station_addr`. The first received byte is compared with `station_addr[7:0]` and the sixth with `station_addr[47:40]`.
- R5: The frame length counts every byte including the last. A frame shorter than MIN_LEN (64) bytes is rejected unless `cfg_acc_runt` is 1. A frame shorter than 6 bytes is always rejected.
- R6: A frame whose last byte carries `in_crc_err` or `in_align_err` at 1 is rejected unless `cfg_keep_bad` is 1.
- R7: `dec_group` is 1 for an accepted broadcast or group frame and 0 for an accepted unicast frame. It is 0 whenever `dec_accept` is 0.
- R8: `dec_valid` is high for exactly the one cycle after the cycle in which the last byte (`in_valid` and `in_last`) is taken. `dec_accept` and `dec_group` are 0 whenever `dec_valid` is 0.
- R9: After reset, `dec_valid`, `dec_accept` and `dec_group` are 0.
- R10: A new frame may start in the cycle right after a last byte. Its address, hash and length start afresh and its verdict is independent of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A frame byte is present on `in_data` |
| in_data | input | 8 | Frame byte, destination address first |
| in_last | input | 1 | Qualifies the final byte of the frame |
| in_crc_err | input | 1 | CRC failure, sampled with the last byte |
| in_align_err | input | 1 | Alignment failure, sampled with the last byte |
| station_addr | input | 48 | Own address, first received byte in bits 7:0 |
| hash_table | input | 64 | Group hash bins, bin n at bit n |
| cfg_acc_bcast | input | 1 | Enable broadcast acceptance |
| cfg_acc_mcast | input | 1 | Enable hashed group acceptance |
| cfg_promisc | input | 1 | Accept every unicast destination |
| cfg_acc_runt | input | 1 | Keep frames shorter than MIN_LEN |
| cfg_keep_bad | input | 1 | Keep frames with CRC or alignment errors |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Frame is accepted |
| dec_group | output | 1 | Accepted through broadcast or group match |

## Verification
The bench builds the filter with its defaults, MIN_LEN = 64 and a 12-bit length counter. This puts the 63/64-byte edge and the under-six-byte case within a few dozen cycles per frame. Lengths stay under 110 bytes, so the saturating counter never reaches its limit, and that corner is left to inspection. The bench forces hash hits and misses by computing each address's bin itself and then setting or clearing exactly that bit of the table. Chained frames with no idle gap test the restart of the address, CRC and length state.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
    localparam int unsigned ADDR_BYTES = 6;
    localparam int unsigned ADDR_W     = ADDR_BYTES * 8;
    localparam int unsigned HASH_BINS  = 64;
    localparam int unsigned HASH_IDX_W = $clog2(HASH_BINS);
    localparam int unsigned CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    typedef struct packed {
        logic acc_bcast;
        logic acc_mcast;
        logic promisc;
        logic acc_runt;
        logic keep_bad;
    } filt_cfg_t;

    // Advance the CRC register over one byte, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_feed_byte(input logic [CRC_W-1:0] c,
                                                       input logic [7:0] b);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[CRC_W-1] ^ b[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction
endpackage

// File: rtl/rxaf_capture.sv
module rxaf_capture
    import rxaf_pkg::*;
#(
    parameter int unsigned LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic [ADDR_W-1:0] dest_now,
    output logic [LEN_W-1:0]  len_now,
    output logic              addr_phase
);
    localparam logic [LEN_W-1:0] LEN_MAX  = '1;
    localparam logic [LEN_W-1:0] ADDR_END = LEN_W'(ADDR_BYTES);

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] dest;
    } cap_t;

    cap_t cap_q, cap_adv, cap_d;

    always_comb begin
        cap_adv = cap_q;
        if (in_valid) begin
            for (int k = 0; k < int'(ADDR_BYTES); k++) begin
                if (cap_q.len == LEN_W'(k)) cap_adv.dest[k*8 +: 8] = in_data;
            end
            if (cap_q.len != LEN_MAX) cap_adv.len = cap_q.len + 1'b1;
        end
        cap_d = cap_adv;
        // the next frame restarts its byte count (R10)
        if (in_valid && in_last) cap_d.len = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign dest_now   = cap_adv.dest;
    assign len_now    = cap_adv.len;
    assign addr_phase = (cap_q.len < ADDR_END);

    // R10: the length count starts from zero after a last byte
    a_r10_len_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> (addr_phase && !$stable(cap_q.len) || cap_q.len == '0));
endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash
    import rxaf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    input  logic                  in_last,
    input  logic                  addr_phase,
    output logic [HASH_IDX_W-1:0] hash_idx_now
);
    logic [CRC_W-1:0] crc_q, crc_adv, crc_d;

    always_comb begin
        crc_adv = crc_q;
        if (in_valid && addr_phase) crc_adv = crc_feed_byte(crc_q, in_data);
        crc_d = crc_adv;
        if (in_valid && in_last) crc_d = CRC_SEED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_SEED;
        else        crc_q <= crc_d;
    end

    // R3: the bin index is the top six bits of the register
    assign hash_idx_now = crc_adv[CRC_W-1 -: HASH_IDX_W];

    // R3: outside the address bytes the register does not move
    a_r3_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_phase && !(in_valid && in_last)) |=> $stable(crc_q));
endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
    import rxaf_pkg::*;
#(
    parameter int unsigned LEN_W   = 12,
    parameter int unsigned MIN_LEN = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  logic                  bad_crc,
    input  logic                  bad_align,
    input  logic [ADDR_W-1:0]     dest,
    input  logic [LEN_W-1:0]      len,
    input  logic [HASH_IDX_W-1:0] hash_idx,
    input  logic [ADDR_W-1:0]     station,
    input  logic [HASH_BINS-1:0]  hash_table,
    input  filt_cfg_t             cfg,
    output logic                  dec_valid,
    output logic                  dec_accept,
    output logic                  dec_group
);
    localparam logic [LEN_W-1:0] LEN_MIN  = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LEN_ADDR = LEN_W'(ADDR_BYTES);

    typedef struct packed {
        logic valid;
        logic accept;
        logic group;
    } dec_t;

    dec_t dec_q, dec_d;
    logic is_group, is_bcast, addr_ok, len_ok, clean_ok;

    always_comb begin
        is_group = dest[0];
        is_bcast = &dest;
        if (is_bcast)      addr_ok = cfg.acc_bcast;                        // R1
        else if (is_group) addr_ok = cfg.acc_mcast && hash_table[hash_idx]; // R2
        else               addr_ok = cfg.promisc || (dest == station);      // R4
        len_ok   = (len >= LEN_ADDR) && ((len >= LEN_MIN) || cfg.acc_runt); // R5
        clean_ok = !(bad_crc || bad_align) || cfg.keep_bad;                 // R6
        dec_d.valid  = fire;
        dec_d.accept = fire && addr_ok && len_ok && clean_ok;
        dec_d.group  = fire && addr_ok && len_ok && clean_ok && is_group;  // R7
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;
    assign dec_group  = dec_q.group;

    a_r1_bcast_off: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (&dest) && !cfg.acc_bcast) |=> !dec_accept);
    a_r5_runt_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !cfg.acc_runt && (len < LEN_MIN)) |=> !dec_accept);
    a_r6_err_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (bad_crc || bad_align) && !cfg.keep_bad) |=> !dec_accept);
    a_r7_group_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        dec_group |-> dec_accept);
    a_r8_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(fire));
    a_r8_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept && !dec_group);
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxaf_pkg::*;
#(
    parameter int unsigned LEN_W   = 12,
    parameter int unsigned MIN_LEN = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic        in_crc_err,
    input  logic        in_align_err,
    input  logic [47:0] station_addr,
    input  logic [63:0] hash_table,
    input  logic        cfg_acc_bcast,
    input  logic        cfg_acc_mcast,
    input  logic        cfg_promisc,
    input  logic        cfg_acc_runt,
    input  logic        cfg_keep_bad,
    output logic        dec_valid,
    output logic        dec_accept,
    output logic        dec_group
);
    logic [ADDR_W-1:0]     dest_now;
    logic [LEN_W-1:0]      len_now;
    logic                  addr_phase;
    logic [HASH_IDX_W-1:0] hash_idx_now;
    filt_cfg_t             cfg;

    always_comb begin
        cfg.acc_bcast = cfg_acc_bcast;
        cfg.acc_mcast = cfg_acc_mcast;
        cfg.promisc   = cfg_promisc;
        cfg.acc_runt  = cfg_acc_runt;
        cfg.keep_bad  = cfg_keep_bad;
    end

    rxaf_capture #(.LEN_W(LEN_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .dest_now(dest_now), .len_now(len_now),
        .addr_phase(addr_phase)
    );

    rxaf_hash u_hash (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .addr_phase(addr_phase), .hash_idx_now(hash_idx_now)
    );

    rxaf_decide #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_decide (
        .clk(clk), .rst_n(rst_n), .fire(in_valid && in_last),
        .bad_crc(in_crc_err), .bad_align(in_align_err), .dest(dest_now),
        .len(len_now), .hash_idx(hash_idx_now), .station(station_addr),
        .hash_table(hash_table), .cfg(cfg), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_group(dec_group)
    );
endmodule

// File: tb/tb_rx_dest_filter.sv
module tb_rx_dest_filter;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_LEN    = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_crc_err = 1'b0, in_align_err = 1'b0;
    logic [47:0] station_addr = 48'hBC9A_7856_3412;
    logic [63:0] hash_table = '0;
    logic        cfg_acc_bcast = 0, cfg_acc_mcast = 0, cfg_promisc = 0;
    logic        cfg_acc_runt = 0, cfg_keep_bad = 0;
    logic        dec_valid, dec_accept, dec_group;

    int checks = 0;
    int errors = 0;
    logic [7:0] fb [0:127];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_dest_filter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_crc_err(in_crc_err), .in_align_err(in_align_err),
        .station_addr(station_addr), .hash_table(hash_table),
        .cfg_acc_bcast(cfg_acc_bcast), .cfg_acc_mcast(cfg_acc_mcast),
        .cfg_promisc(cfg_promisc), .cfg_acc_runt(cfg_acc_runt),
        .cfg_keep_bad(cfg_keep_bad), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_group(dec_group)
    );

    task automatic check3(input string tag, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got valid/accept/group %b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic [5:0] bin_of();
        logic [31:0] c;
        logic        f;
        c = '1;
        for (int k = 0; k < 6; k++)
            for (int b = 0; b < 8; b++) begin
                f = c[31] ^ fb[k][b];
                c = {c[30:0], 1'b0} ^ (f ? 32'h04C11DB7 : 32'h0);
            end
        return c[31:26];
    endfunction

    function automatic logic [2:0] model(input int len, input bit ce, input bit ae);
        logic [47:0] da;
        bit ok, grp;
        for (int k = 0; k < 6; k++) da[k*8 +: 8] = fb[k];
        grp = da[0];
        if (len < 6) return 3'b100;
        if (&da)      ok = cfg_acc_bcast;
        else if (grp) ok = cfg_acc_mcast && hash_table[bin_of()];
        else          ok = cfg_promisc || (da == station_addr);
        if (len < MIN_LEN && !cfg_acc_runt) ok = 0;
        if ((ce || ae) && !cfg_keep_bad) ok = 0;
        return {1'b1, ok, ok && grp};
    endfunction

    // cls: 0 broadcast, 1 group, 2 own station, 3 other unicast
    task automatic fill_frame(input int cls);
        for (int i = 0; i < 128; i++) fb[i] = 8'($urandom);
        for (int k = 0; k < 6; k++) begin
            case (cls)
                0: fb[k] = 8'hFF;
                2: fb[k] = station_addr[k*8 +: 8];
                default: ;
            endcase
        end
        if (cls == 1) begin
            fb[0][0] = 1'b1;
            if (fb[1] == 8'hFF) fb[1] = 8'h00;
        end
        if (cls == 3) begin
            fb[0][0] = 1'b0;
            if (fb[1] == station_addr[15:8]) fb[1] = ~fb[1];
        end
    endtask

    task automatic set_cfg(input bit b, input bit m, input bit p, input bit r, input bit k);
        cfg_acc_bcast = b; cfg_acc_mcast = m; cfg_promisc = p;
        cfg_acc_runt = r; cfg_keep_bad = k;
    endtask

    // Called at a negedge; returns at the negedge where the verdict is visible.
    task automatic run_frame(input string tag, input int len, input bit ce,
                             input bit ae, input bit chain, input logic [2:0] exp);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1; in_data = fb[i]; in_last = (i == len - 1);
            in_crc_err = ce; in_align_err = ae;
            @(negedge clk);
        end
        check3(tag, {dec_valid, dec_accept, dec_group}, exp);
        if (!chain) begin
            in_valid = 1'b0; in_last = 1'b0; in_crc_err = 1'b0; in_align_err = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] bin;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check3("R9 reset outputs", {dec_valid, dec_accept, dec_group}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R7 broadcast
        set_cfg(1, 0, 0, 0, 0); fill_frame(0);
        run_frame("R1 R7 broadcast enabled", 64, 0, 0, 0, 3'b111);
        set_cfg(0, 1, 0, 0, 0); hash_table = '1; fill_frame(0);
        run_frame("R1 broadcast disabled", 64, 0, 0, 0, 3'b100);

        // R2 / R3 hashed group
        set_cfg(0, 1, 0, 0, 0); fill_frame(1); bin = bin_of();
        hash_table = 64'd1 << bin;
        run_frame("R3 group hash hit", 70, 0, 0, 0, 3'b111);
        fill_frame(1); bin = bin_of(); hash_table = ~(64'd1 << bin);
        run_frame("R3 group hash miss", 70, 0, 0, 0, 3'b100);
        set_cfg(1, 0, 1, 1, 1); hash_table = '1; fill_frame(1);
        run_frame("R2 group disabled", 70, 0, 0, 0, 3'b100);

        // R4 unicast
        set_cfg(1, 1, 0, 0, 0); fill_frame(2);
        run_frame("R4 R7 station match", 64, 0, 0, 0, 3'b110);
        fill_frame(3);
        run_frame("R4 other unicast dropped", 64, 0, 0, 0, 3'b100);
        cfg_promisc = 1; fill_frame(3);
        run_frame("R4 promiscuous unicast", 64, 0, 0, 0, 3'b110);

        // R5 length
        set_cfg(0, 0, 0, 0, 0); fill_frame(2);
        run_frame("R5 63 bytes dropped", 63, 0, 0, 0, 3'b100);
        run_frame("R5 64 bytes kept", 64, 0, 0, 0, 3'b110);
        cfg_acc_runt = 1;
        run_frame("R5 runt kept", 63, 0, 0, 0, 3'b110);
        run_frame("R5 five bytes dropped", 5, 0, 0, 0, 3'b100);
        run_frame("R5 six bytes kept", 6, 0, 0, 0, 3'b110);

        // R6 errors
        set_cfg(0, 0, 0, 0, 0);
        run_frame("R6 crc error dropped", 64, 1, 0, 0, 3'b100);
        run_frame("R6 align error dropped", 64, 0, 1, 0, 3'b100);
        cfg_keep_bad = 1;
        run_frame("R6 crc error kept", 64, 1, 0, 0, 3'b110);

        // R10 back to back, then R8 single-cycle pulse
        set_cfg(1, 0, 0, 0, 0); fill_frame(3);
        run_frame("R10 first chained", 64, 0, 0, 1, 3'b100);
        fill_frame(0);
        run_frame("R10 second chained", 64, 0, 0, 0, 3'b111);
        @(negedge clk);
        check3("R8 pulse ends", {dec_valid, dec_accept, dec_group}, 3'b000);

        // random mix covering R1 R2 R4 R5 R6 R10
        for (int n = 0; n < 300; n++) begin
            int len;
            bit ce, ae, ch;
            set_cfg(1'($urandom), 1'($urandom), ($urandom % 4) == 0,
                    1'($urandom), 1'($urandom));
            hash_table = {$urandom, $urandom};
            fill_frame(int'($urandom % 4));
            case ($urandom % 4)
                0: len = 1 + int'($urandom % 8);
                1: len = 58 + int'($urandom % 12);
                2: len = 64 + int'($urandom % 40);
                default: len = 6 + int'($urandom % 60);
            endcase
            ce = ($urandom % 5) == 0;
            ae = ($urandom % 7) == 0;
            ch = ($urandom % 3) == 0;
            run_frame("random R2 R4 R5 R6", len, ce, ae, ch, model(len, ce, ae));
        end
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule